// File: doc/BRIEF.md
# Serial NOR Flash Command Engine

This block is a byte-level slave model of a serial NOR flash device. The SPI bit shifting is done elsewhere. The engine sees one received byte per strobe while the chip is selected and returns one response byte per strobe. The first byte after an idle point is an opcode. The engine then gathers the address or parameter bytes the opcode needs and runs the command. It supports byte-stream reads, page programming, status, flag and identification reads, the write-enable latch, a 4-byte addressing mode, a register that supplies the top address byte in 3-byte mode, and a two-step software reset.

The storage is a small internal byte array sized by a parameter. It comes out of reset fully erased (0xFF). Erase commands do not change the array. They are passed to surrounding logic as a one-cycle request carrying the erase address and scope. Each response byte appears on `dout_o` in the cycle after the strobe that produced it and holds until the next strobe. Dropping the select ends the current command in that cycle.

Top module: `nor_cmd_engine`

## Requirements
- R1: After reset the array reads 0xFF everywhere, the write-enable latch is clear, 3-byte addressing is active, the upper-address register is 0x00, and `dout_o` and `erase_req_o` are 0.
- R2: A strobe taken while `sel_i` is high updates `dout_o` after that clock edge, and `dout_o` holds between strobes. Opcode, address and parameter strobes return 0x00.
- R3: Opcode 0x06 sets the write-enable latch and 0x04 clears it. Opcode 0x05 returns one byte with the latch in bit 1 and all other bits 0. After the last response byte of any register read, the next byte in the same selection is decoded as a new opcode.
- R4: Opcode 0x03 takes the address most significant byte first. Each following strobe returns the array byte at the current address and advances the address by one, wrapping modulo ARRAY_BYTES.
- R5: Opcode 0x02 takes an address and then programs one byte per strobe with the same increment and wrap as R4. With EEPROM_MODE=0 the stored byte becomes the AND of the old and new bytes. With EEPROM_MODE=1 the new byte replaces the old one.
- R6: While the write-enable latch is clear, program data, sector erase (0xD8), chip erase (0xC7), upper-address writes (0xC5) and status writes (0x01) have no effect.
- R7: Opcode 0xB7 selects 4-byte addresses and 0xE9 selects 3-byte addresses. Opcode 0x70 returns bit 7 = 1, bit 0 = 4-byte mode, and all other bits 0.
- R8: Opcode 0xC8 returns the upper-address register. Opcode 0xC5 loads it from one parameter byte. In 3-byte mode that register forms address bits 31:24. Every collected address is then masked to ARRAY_BYTES-1.
- R9: Opcode 0x9F returns the three bytes of ID_CODE, most significant byte first.
- R10: With the latch set, 0xD8 followed by an address raises `erase_req_o` for one cycle after its last address byte, with `erase_all_o`=0 and the masked address on `erase_addr_o`. With the latch set, 0xC7 raises `erase_req_o` for one cycle after the opcode, with `erase_all_o`=1 and `erase_addr_o`=0. The array contents do not change.
- R11: Opcode 0x99 clears the latch, the 4-byte mode and the upper-address register only if the opcode decoded just before it was 0x66. Any other opcode in between cancels the pending reset.
- R12: With the latch set, opcode 0x01 collects a variable number of bytes until deselect. On deselect the latch clears, and if at least two bytes arrived, bit 5 of the second byte becomes the 4-byte mode.
- R13: The parameter buffer holds BUF_DEPTH bytes. A parameter strobe arriving when it is full discards the command and returns to idle, so a later deselect completes nothing.
- R14: While `sel_i` is low, strobes are ignored, and any command in progress is abandoned with a return to idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sel_i | input | 1 | Chip selected, active high |
| strb_i | input | 1 | One received byte is valid this cycle |
| din_i | input | 8 | Received byte |
| dout_o | output | 8 | Response byte for the most recent strobe |
| erase_req_o | output | 1 | One-cycle erase request |
| erase_all_o | output | 1 | Erase request covers the whole array |
| erase_addr_o | output | $clog2(ARRAY_BYTES) | Erase address (sector erase) |

## Verification
The assertions check the following on every cycle: a deselect always lands in idle, `dout_o` holds when no strobe is taken, an erase request is never raised unless the latch was set, a reset opcode without the arming opcode leaves the latch and the upper-address register unchanged, 0xB7 takes effect, the buffer length never exceeds its depth, and a program without EEPROM mode never turns a 0 bit into a 1. Other behaviours need whole command sequences and can only be shown by the bench scenarios: address assembly from the upper-address register and the size mask, wrap-around during a burst, the variable-length status write ending at deselect, the overrun that leaves the latch set, and the difference between AND programming and overwrite programming.

// File: rtl/nor_cmd_pkg.sv
package nor_cmd_pkg;
  timeunit 1ns; timeprecision 1ps;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_FIXED,
    ST_VARLEN,
    ST_PROG,
    ST_READ,
    ST_RESP
  } nor_state_e;

  localparam logic [7:0] OP_WR_EN    = 8'h06;
  localparam logic [7:0] OP_WR_DIS   = 8'h04;
  localparam logic [7:0] OP_RD_STAT  = 8'h05;
  localparam logic [7:0] OP_WR_STAT  = 8'h01;
  localparam logic [7:0] OP_RD_FLAG  = 8'h70;
  localparam logic [7:0] OP_RD_ARR   = 8'h03;
  localparam logic [7:0] OP_PROG     = 8'h02;
  localparam logic [7:0] OP_SEC_ER   = 8'hD8;
  localparam logic [7:0] OP_CHIP_ER  = 8'hC7;
  localparam logic [7:0] OP_RD_ID    = 8'h9F;
  localparam logic [7:0] OP_ADDR4_ON = 8'hB7;
  localparam logic [7:0] OP_ADDR4_OFF= 8'hE9;
  localparam logic [7:0] OP_RD_SEG   = 8'hC8;
  localparam logic [7:0] OP_WR_SEG   = 8'hC5;
  localparam logic [7:0] OP_RST_ARM  = 8'h66;
  localparam logic [7:0] OP_RST_GO   = 8'h99;
endpackage

// File: rtl/nor_xfer_buf.sv
module nor_xfer_buf #(
  parameter int DEPTH = 16,
  parameter int LD_N  = 3,
  localparam int IDX_W = $clog2(DEPTH),
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  clr_i,
  input  logic                  push_i,
  input  logic [7:0]            push_data_i,
  input  logic                  load_i,
  input  logic [LD_N-1:0][7:0]  load_data_i,
  input  logic [CNT_W-1:0]      load_len_i,
  input  logic                  pop_i,
  output logic [7:0]            pop_data_o,
  output logic [CNT_W-1:0]      len_o,
  output logic [CNT_W-1:0]      pos_o,
  output logic                  full_o
);
  timeunit 1ns; timeprecision 1ps;

  logic [7:0]       mem_q [DEPTH];
  logic [CNT_W-1:0] len_q, pos_q;

  assign full_o     = (len_q == CNT_W'(DEPTH));
  assign len_o      = len_q;
  assign pos_o      = pos_q;
  assign pop_data_o = mem_q[pos_q[IDX_W-1:0]];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      len_q <= '0;
      pos_q <= '0;
      for (int i = 0; i < DEPTH; i++) mem_q[i] <= '0;
    end else if (load_i) begin
      for (int i = 0; i < LD_N; i++) mem_q[i] <= load_data_i[i];
      len_q <= load_len_i;
      pos_q <= '0;
    end else if (clr_i) begin
      len_q <= '0;
      pos_q <= '0;
    end else begin
      if (push_i && !full_o) begin
        mem_q[len_q[IDX_W-1:0]] <= push_data_i;
        len_q <= len_q + CNT_W'(1);
      end
      if (pop_i) pos_q <= pos_q + CNT_W'(1);
    end
  end

  // R13
  no_overflow_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    len_q <= CNT_W'(DEPTH));

  // R13
  full_push_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (push_i && full_o && !clr_i && !load_i) |=> (len_q == CNT_W'(DEPTH)));
endmodule

// File: rtl/nor_cell_array.sv
module nor_cell_array #(
  parameter int BYTES       = 256,
  parameter bit EEPROM_MODE = 1'b0,
  localparam int AW = $clog2(BYTES)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [AW-1:0] addr_i,
  input  logic          we_i,
  input  logic [7:0]    wdata_i,
  output logic [7:0]    rdata_o
);
  timeunit 1ns; timeprecision 1ps;

  logic [7:0] mem_q [BYTES];
  logic [7:0] wr_val;

  assign rdata_o = mem_q[addr_i];

  generate
    if (EEPROM_MODE) begin : g_overwrite
      assign wr_val = wdata_i;
    end else begin : g_clear_only
      assign wr_val = rdata_o & wdata_i;
    end
  endgenerate

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < BYTES; i++) mem_q[i] <= 8'hFF;
    end else if (we_i) begin
      mem_q[addr_i] <= wr_val;
    end
  end

  generate
    if (!EEPROM_MODE) begin : g_prog_chk
      logic          chk_we_q;
      logic [AW-1:0] chk_addr_q;
      logic [7:0]    chk_old_q;
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
          chk_we_q   <= 1'b0;
          chk_addr_q <= '0;
          chk_old_q  <= 8'hFF;
        end else begin
          chk_we_q   <= we_i;
          chk_addr_q <= addr_i;
          chk_old_q  <= rdata_o;
        end
      end
      // R5
      prog_no_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        chk_we_q |-> ((mem_q[chk_addr_q] & ~chk_old_q) == 8'h00));
    end
  endgenerate
endmodule

// File: rtl/nor_cmd_engine.sv
module nor_cmd_engine
  import nor_cmd_pkg::*;
#(
  parameter int          ARRAY_BYTES = 256,
  parameter int          BUF_DEPTH   = 16,
  parameter logic [23:0] ID_CODE     = 24'h5A_C3_17,
  parameter bit          EEPROM_MODE = 1'b0,
  localparam int AW    = $clog2(ARRAY_BYTES),
  localparam int CNT_W = $clog2(BUF_DEPTH + 1),
  localparam int LD_N  = 3
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          sel_i,
  input  logic          strb_i,
  input  logic [7:0]    din_i,
  output logic [7:0]    dout_o,
  output logic          erase_req_o,
  output logic          erase_all_o,
  output logic [AW-1:0] erase_addr_o
);
  timeunit 1ns; timeprecision 1ps;

  nor_state_e       st_q, st_d;
  logic [7:0]       op_q, op_d;
  logic [CNT_W-1:0] need_q, need_d;
  logic [AW-1:0]    addr_q, addr_d;
  logic [23:0]      shift_q, shift_d;
  logic             wel_q, wel_d, four_q, four_d, arm_q, arm_d;
  logic             mbit_q, mbit_d;
  logic [7:0]       seg_q, seg_d, dout_q, dout_d;
  logic             er_req_q, er_req_d, er_all_q, er_all_d;
  logic [AW-1:0]    er_addr_q, er_addr_d;

  logic             buf_clr, buf_push, buf_load, buf_pop, buf_full;
  logic [LD_N-1:0][7:0] ld_data;
  logic [CNT_W-1:0] ld_len, buf_len, buf_pos;
  logic [7:0]       buf_rd;
  logic [7:0]       arr_rd;
  logic             arr_we;
  logic [31:0]      shift_nxt;
  logic [AW-1:0]    coll_addr;
  logic [CNT_W-1:0] alen;
  logic             strobe;

  assign strobe    = sel_i && strb_i;
  assign alen      = four_q ? CNT_W'(4) : CNT_W'(3);
  assign shift_nxt = {shift_q, din_i};
  // 3-byte mode borrows the top address byte from the upper-address register
  assign coll_addr = AW'(four_q ? shift_nxt : {seg_q, shift_nxt[23:0]});
  assign arr_we    = strobe && (st_q == ST_PROG) && wel_q;

  nor_xfer_buf #(.DEPTH(BUF_DEPTH), .LD_N(LD_N)) u_buf (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .clr_i       (buf_clr),
    .push_i      (buf_push),
    .push_data_i (din_i),
    .load_i      (buf_load),
    .load_data_i (ld_data),
    .load_len_i  (ld_len),
    .pop_i       (buf_pop),
    .pop_data_o  (buf_rd),
    .len_o       (buf_len),
    .pos_o       (buf_pos),
    .full_o      (buf_full)
  );

  nor_cell_array #(.BYTES(ARRAY_BYTES), .EEPROM_MODE(EEPROM_MODE)) u_arr (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .addr_i  (addr_q),
    .we_i    (arr_we),
    .wdata_i (din_i),
    .rdata_o (arr_rd)
  );

  always_comb begin
    st_d      = st_q;
    op_d      = op_q;
    need_d    = need_q;
    addr_d    = addr_q;
    shift_d   = shift_q;
    wel_d     = wel_q;
    four_d    = four_q;
    arm_d     = arm_q;
    mbit_d    = mbit_q;
    seg_d     = seg_q;
    dout_d    = dout_q;
    er_req_d  = 1'b0;
    er_all_d  = er_all_q;
    er_addr_d = er_addr_q;
    buf_clr   = 1'b0;
    buf_push  = 1'b0;
    buf_load  = 1'b0;
    buf_pop   = 1'b0;
    ld_data   = '0;
    ld_len    = '0;

    if (!sel_i) begin
      if (st_q == ST_VARLEN) begin
        wel_d = 1'b0;
        if (buf_len >= CNT_W'(2)) four_d = mbit_q;
      end
      st_d    = ST_IDLE;
      buf_clr = 1'b1;
    end else if (strb_i) begin
      case (st_q)
        ST_IDLE: begin
          dout_d  = 8'h00;
          op_d    = din_i;
          shift_d = '0;
          buf_clr = 1'b1;
          if (din_i != OP_RST_GO) arm_d = 1'b0;
          case (din_i)
            OP_WR_EN:     wel_d = 1'b1;
            OP_WR_DIS:    wel_d = 1'b0;
            OP_RD_STAT: begin
              ld_data[0] = {6'b0, wel_q, 1'b0};
              ld_len     = CNT_W'(1);
              buf_load   = 1'b1;
              st_d       = ST_RESP;
            end
            OP_RD_FLAG: begin
              ld_data[0] = {1'b1, 6'b0, four_q};
              ld_len     = CNT_W'(1);
              buf_load   = 1'b1;
              st_d       = ST_RESP;
            end
            OP_RD_ID: begin
              ld_data[0] = ID_CODE[23:16];
              ld_data[1] = ID_CODE[15:8];
              ld_data[2] = ID_CODE[7:0];
              ld_len     = CNT_W'(3);
              buf_load   = 1'b1;
              st_d       = ST_RESP;
            end
            OP_RD_SEG: begin
              ld_data[0] = seg_q;
              ld_len     = CNT_W'(1);
              buf_load   = 1'b1;
              st_d       = ST_RESP;
            end
            OP_WR_SEG: begin
              if (wel_q) begin
                need_d = CNT_W'(1);
                st_d   = ST_FIXED;
              end
            end
            OP_RD_ARR, OP_PROG, OP_SEC_ER: begin
              need_d = alen;
              st_d   = ST_FIXED;
            end
            OP_CHIP_ER: begin
              if (wel_q) begin
                er_req_d  = 1'b1;
                er_all_d  = 1'b1;
                er_addr_d = '0;
              end
            end
            OP_ADDR4_ON:  four_d = 1'b1;
            OP_ADDR4_OFF: four_d = 1'b0;
            OP_RST_ARM:   arm_d  = 1'b1;
            OP_RST_GO: begin
              if (arm_q) begin
                wel_d  = 1'b0;
                four_d = 1'b0;
                seg_d  = 8'h00;
                arm_d  = 1'b0;
              end
            end
            OP_WR_STAT: begin
              if (wel_q) st_d = ST_VARLEN;
            end
            default: ;
          endcase
        end
        ST_FIXED, ST_VARLEN: begin
          dout_d = 8'h00;
          if (buf_full) begin
            buf_clr = 1'b1;
            st_d    = ST_IDLE;
          end else begin
            buf_push = 1'b1;
            shift_d  = shift_nxt[23:0];
            if (buf_len == CNT_W'(1)) mbit_d = din_i[5];
            if (st_q == ST_FIXED && (buf_len + CNT_W'(1)) == need_q) begin
              st_d = ST_IDLE;
              case (op_q)
                OP_RD_ARR: begin
                  addr_d = coll_addr;
                  st_d   = ST_READ;
                end
                OP_PROG: begin
                  addr_d = coll_addr;
                  st_d   = ST_PROG;
                end
                OP_SEC_ER: begin
                  if (wel_q) begin
                    er_req_d  = 1'b1;
                    er_all_d  = 1'b0;
                    er_addr_d = coll_addr;
                  end
                end
                OP_WR_SEG: seg_d = din_i;
                default: ;
              endcase
            end
          end
        end
        ST_PROG: begin
          dout_d = 8'h00;
          addr_d = addr_q + AW'(1);
        end
        ST_READ: begin
          dout_d = arr_rd;
          addr_d = addr_q + AW'(1);
        end
        ST_RESP: begin
          dout_d  = buf_rd;
          buf_pop = 1'b1;
          if ((buf_pos + CNT_W'(1)) == buf_len) st_d = ST_IDLE;
        end
        default: st_d = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q      <= ST_IDLE;
      op_q      <= 8'h00;
      need_q    <= '0;
      addr_q    <= '0;
      shift_q   <= '0;
      wel_q     <= 1'b0;
      four_q    <= 1'b0;
      arm_q     <= 1'b0;
      mbit_q    <= 1'b0;
      seg_q     <= 8'h00;
      dout_q    <= 8'h00;
      er_req_q  <= 1'b0;
      er_all_q  <= 1'b0;
      er_addr_q <= '0;
    end else begin
      st_q      <= st_d;
      op_q      <= op_d;
      need_q    <= need_d;
      addr_q    <= addr_d;
      shift_q   <= shift_d;
      wel_q     <= wel_d;
      four_q    <= four_d;
      arm_q     <= arm_d;
      mbit_q    <= mbit_d;
      seg_q     <= seg_d;
      dout_q    <= dout_d;
      er_req_q  <= er_req_d;
      er_all_q  <= er_all_d;
      er_addr_q <= er_addr_d;
    end
  end

  assign dout_o       = dout_q;
  assign erase_req_o  = er_req_q;
  assign erase_all_o  = er_all_q;
  assign erase_addr_o = er_addr_q;

  // R14
  desel_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !sel_i |=> (st_q == ST_IDLE));

  // R2
  dout_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !strobe |=> $stable(dout_q));

  // R10
  erase_needs_wel_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    erase_req_o |-> $past(wel_q));

  // R7
  addr4_on_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (strobe && st_q == ST_IDLE && din_i == OP_ADDR4_ON) |=> four_q);

  // R11
  rst_unarmed_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (strobe && st_q == ST_IDLE && din_i == OP_RST_GO && !arm_q)
      |=> (wel_q == $past(wel_q) && seg_q == $past(seg_q)));
endmodule

// File: tb/nor_cmd_engine_tb_top.sv
module nor_cmd_engine_tb_top;
  timeunit 1ns; timeprecision 1ps;

  localparam logic [23:0] ID = 24'h5A_C3_17;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       sel = 1'b0, strb = 1'b0;
  logic [7:0] din = 8'h00;
  logic [7:0] dout, dout_ee;
  logic       er_req, er_all, er_req_ee, er_all_ee;
  logic [7:0] er_addr, er_addr_ee;

  always #5 clk = ~clk;

  nor_cmd_engine #(.ID_CODE(ID)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .sel_i(sel), .strb_i(strb), .din_i(din),
    .dout_o(dout), .erase_req_o(er_req), .erase_all_o(er_all), .erase_addr_o(er_addr));

  nor_cmd_engine #(.ID_CODE(ID), .EEPROM_MODE(1'b1)) dut_ee_i (
    .clk_i(clk), .rst_ni(rst_n), .sel_i(sel), .strb_i(strb), .din_i(din),
    .dout_o(dout_ee), .erase_req_o(er_req_ee), .erase_all_o(er_all_ee),
    .erase_addr_o(er_addr_ee));

  int checks = 0, fails = 0;
  bit cmp_en = 1'b0;
  string cur_req = "R1";

  // behavioural reference
  logic [7:0] m_mem [256];
  int         m_st = 0, m_need = 0, m_addr = 0;
  logic [7:0] m_op = 0, m_seg = 0;
  bit         m_wel = 0, m_four = 0, m_arm = 0;
  logic [7:0] m_param[$];
  logic [7:0] m_resp[$];
  logic [7:0] exp_dout = 0;
  bit         exp_er = 0, exp_all = 0;
  int         exp_eaddr = 0;
  logic [7:0] q[$];

  task automatic chk(bit ok, string req, string what, int act, int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic int coll_addr();
    int a = 0;
    foreach (m_param[i]) a = (a << 8) | int'(m_param[i]);
    if (!m_four) a = a | (int'(m_seg) << 24);
    return a & 255;
  endfunction

  task automatic model_byte(logic [7:0] b);
    case (m_st)
      0: begin
        exp_dout = 0; m_op = b; m_param.delete(); m_resp.delete();
        if (b != 8'h99) m_arm = 0;
        case (b)
          8'h06: m_wel = 1;
          8'h04: m_wel = 0;
          8'h05: begin m_resp.push_back(m_wel ? 8'h02 : 8'h00); m_st = 5; end
          8'h70: begin m_resp.push_back(m_four ? 8'h81 : 8'h80); m_st = 5; end
          8'h9F: begin
            m_resp.push_back(ID[23:16]); m_resp.push_back(ID[15:8]);
            m_resp.push_back(ID[7:0]); m_st = 5;
          end
          8'hC8: begin m_resp.push_back(m_seg); m_st = 5; end
          8'hC5: if (m_wel) begin m_need = 1; m_st = 1; end
          8'h03, 8'h02, 8'hD8: begin m_need = m_four ? 4 : 3; m_st = 1; end
          8'hC7: if (m_wel) begin exp_er = 1; exp_all = 1; exp_eaddr = 0; end
          8'hB7: m_four = 1;
          8'hE9: m_four = 0;
          8'h66: m_arm = 1;
          8'h99: if (m_arm) begin m_wel = 0; m_four = 0; m_seg = 0; m_arm = 0; end
          8'h01: if (m_wel) m_st = 2;
          default: ;
        endcase
      end
      1, 2: begin
        exp_dout = 0;
        if (m_param.size() == 16) begin
          m_param.delete(); m_st = 0;
        end else begin
          m_param.push_back(b);
          if (m_st == 1 && m_param.size() == m_need) begin
            m_st = 0;
            case (m_op)
              8'h03: begin m_addr = coll_addr(); m_st = 4; end
              8'h02: begin m_addr = coll_addr(); m_st = 3; end
              8'hD8: if (m_wel) begin exp_er = 1; exp_all = 0; exp_eaddr = coll_addr(); end
              8'hC5: m_seg = b;
              default: ;
            endcase
          end
        end
      end
      3: begin
        exp_dout = 0;
        if (m_wel) m_mem[m_addr] = m_mem[m_addr] & b;
        m_addr = (m_addr + 1) & 255;
      end
      4: begin
        exp_dout = m_mem[m_addr];
        m_addr = (m_addr + 1) & 255;
      end
      5: begin
        exp_dout = m_resp.pop_front();
        if (m_resp.size() == 0) m_st = 0;
      end
      default: ;
    endcase
  endtask

  task automatic model_desel();
    if (m_st == 2) begin
      m_wel = 0;
      if (m_param.size() >= 2) m_four = m_param[1][5];
    end
    m_st = 0;
    m_param.delete();
    m_resp.delete();
  endtask

  task automatic step(bit s, bit t, logic [7:0] b);
    @(negedge clk);
    sel = s; strb = t; din = b;
    exp_er = 0;
    if (!s) model_desel();
    else if (t) model_byte(b);
  endtask

  task automatic send(logic [7:0] b); step(1'b1, 1'b1, b); endtask
  task automatic desel(); step(1'b0, 1'b0, 8'h00); endtask
  task automatic run_q();
    foreach (q[i]) send(q[i]);
    desel();
  endtask

  // compare the design with the reference on every clock
  always @(posedge clk) begin
    #2;
    if (cmp_en) begin
      chk(dout == exp_dout, cur_req, "dout", int'(dout), int'(exp_dout));
      chk(er_req == exp_er, cur_req, "erase_req", int'(er_req), int'(exp_er));
      if (exp_er) begin
        chk(er_all == exp_all, cur_req, "erase_all", int'(er_all), int'(exp_all));
        chk(int'(er_addr) == exp_eaddr, cur_req, "erase_addr", int'(er_addr), exp_eaddr);
      end
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++; fails++;
    $display("FAIL R14 watchdog actual=running expected=done");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    for (int i = 0; i < 256; i++) m_mem[i] = 8'hFF;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    cmp_en = 1'b1;

    cur_req = "R1";
    desel(); desel();
    q = {8'h05, 8'h00}; run_q();
    q = {8'h70, 8'h00}; run_q();
    q = {8'hC8, 8'h00}; run_q();
    q = {8'h03, 8'h00, 8'h00, 8'h10, 8'h00, 8'h00, 8'h00}; run_q();

    cur_req = "R9";
    q = {8'h9F, 8'h00, 8'h00, 8'h00}; run_q();

    cur_req = "R3";
    q = {8'h06, 8'h05, 8'h00, 8'h05, 8'h00}; run_q();
    q = {8'h04}; run_q();
    q = {8'h05, 8'h00}; run_q();

    cur_req = "R6";
    q = {8'h02, 8'h00, 8'h00, 8'h20, 8'h12}; run_q();
    q = {8'h03, 8'h00, 8'h00, 8'h20, 8'h00}; run_q();

    cur_req = "R5";
    q = {8'h06}; run_q();
    q = {8'h02, 8'h00, 8'h00, 8'h20, 8'h0F, 8'hF0}; run_q();
    q = {8'h02, 8'h00, 8'h00, 8'h20, 8'hF5}; run_q();
    q = {8'h03, 8'h00, 8'h00, 8'h20, 8'h00, 8'h00}; run_q();

    cur_req = "R4";
    q = {8'h02, 8'h00, 8'h00, 8'hFF, 8'hA1, 8'hB2}; run_q();
    q = {8'h03, 8'h00, 8'h00, 8'hFF, 8'h00, 8'h00, 8'h00}; run_q();

    cur_req = "R2";
    send(8'h03); step(1'b1, 1'b0, 8'h00); send(8'h00); send(8'h00);
    step(1'b1, 1'b0, 8'h00); send(8'h20); send(8'h00);
    step(1'b1, 1'b0, 8'h00); step(1'b1, 1'b0, 8'h00); desel();

    cur_req = "R7";
    q = {8'hB7}; run_q();
    q = {8'h70, 8'h00}; run_q();
    q = {8'h03, 8'h12, 8'h34, 8'h56, 8'h20, 8'h00}; run_q();
    q = {8'hE9, 8'h70, 8'h00}; run_q();

    cur_req = "R8";
    q = {8'h04}; run_q();
    q = {8'hC5, 8'h7F}; run_q();
    q = {8'hC8, 8'h00}; run_q();
    q = {8'h06}; run_q();
    q = {8'hC5, 8'h7F}; run_q();
    q = {8'hC8, 8'h00}; run_q();
    q = {8'h03, 8'h00, 8'h00, 8'h20, 8'h00}; run_q();

    cur_req = "R10";
    q = {8'h04}; run_q();
    q = {8'hD8, 8'h00, 8'h00, 8'h40}; run_q();
    q = {8'hC7}; run_q();
    q = {8'h06}; run_q();
    q = {8'hD8, 8'h00, 8'h01, 8'h40}; run_q();
    q = {8'hC7}; run_q();
    q = {8'h03, 8'h00, 8'h00, 8'h20, 8'h00}; run_q();

    cur_req = "R11";
    q = {8'hB7}; run_q();
    q = {8'h66, 8'h00, 8'h99}; run_q();
    q = {8'h70, 8'h00, 8'hC8, 8'h00, 8'h05, 8'h00}; run_q();
    q = {8'h66}; run_q();
    q = {8'h99}; run_q();
    q = {8'h70, 8'h00, 8'hC8, 8'h00, 8'h05, 8'h00}; run_q();

    cur_req = "R12";
    q = {8'h01, 8'h00, 8'h20}; run_q();
    q = {8'h70, 8'h00}; run_q();
    q = {8'h06}; run_q();
    q = {8'h01, 8'h00, 8'h20}; run_q();
    q = {8'h70, 8'h00, 8'h05, 8'h00}; run_q();
    q = {8'h06}; run_q();
    q = {8'h01, 8'h00}; run_q();
    q = {8'h70, 8'h00, 8'h05, 8'h00}; run_q();
    q = {8'h06}; run_q();
    q = {8'h01, 8'h00, 8'h00}; run_q();
    q = {8'h70, 8'h00}; run_q();

    cur_req = "R13";
    q = {8'h06}; run_q();
    q = {8'h01};
    for (int i = 0; i < 17; i++) q.push_back(8'h20);
    run_q();
    q = {8'h05, 8'h00, 8'h70, 8'h00}; run_q();
    q = {8'h01};
    for (int i = 0; i < 16; i++) q.push_back(8'h20);
    run_q();
    q = {8'h05, 8'h00, 8'h70, 8'h00}; run_q();
    q = {8'hE9}; run_q();

    cur_req = "R14";
    q = {8'h03, 8'h00, 8'h00}; run_q();
    q = {8'h05, 8'h00}; run_q();
    step(1'b0, 1'b1, 8'h06);
    step(1'b0, 1'b1, 8'hB7);
    q = {8'h05, 8'h00, 8'h70, 8'h00}; run_q();

    // R5: overwrite variant keeps the new byte, clear-only variant ANDs
    cur_req = "R5";
    q = {8'h06}; run_q();
    q = {8'h02, 8'h00, 8'h00, 8'h80, 8'h0F}; run_q();
    q = {8'h02, 8'h00, 8'h00, 8'h80, 8'h55}; run_q();
    q = {8'h03, 8'h00, 8'h00, 8'h80}; foreach (q[i]) send(q[i]);
    send(8'h00);
    @(posedge clk); #3;
    chk(dout_ee == 8'h55, "R5", "eeprom overwrite", int'(dout_ee), 8'h55);
    chk(dout == 8'h05, "R5", "and program", int'(dout), 8'h05);
    desel(); desel();

    cmp_en = 1'b0;
    @(negedge clk);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule